// File: doc/BRIEF.md
# ADC conversion sequence controller

This block is the digital control engine of a successive-approximation converter peripheral. Software sets a group of configuration fields: enable, a start strobe, sequence mode, highest channel, sample-time code, trigger source, trigger polarity, clock divide, output format and a multiple-sample option. The block then waits for a rising edge on the chosen trigger and times a sample phase from a divided clock. It then sends a one-clock start pulse and a channel number to the analog converter, and waits for the converter's done strobe.

Each returned code is written to a result register. Every load sets an interrupt flag, and a busy flag covers the whole operation. In the two sequence modes the channel counts down from the programmed top channel to channel 0. The two repeat modes keep going until enable is dropped; the current conversion or sequence then finishes before the block goes idle. With the multiple-sample option set, one trigger edge runs the following conversions back to back. With it clear, every conversion waits for a fresh trigger edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, irq_flag, conv_start and result are all 0.
- R2: Let N be 4, 8, 16 or 64 for cfg_sht codes 0, 1, 2 and 3, and let D be cfg_div (0 to 7). If cfg_start is held high for one clock, conv_start goes high 2 + N*(D+1) clock edges later, counted from the edge that captures cfg_start. conv_start is high for exactly one clock.
- R3: Mode 0 (cfg_mode = 0) performs one conversion on channel cfg_chan and then returns busy to 0.
- R4: Mode 1 converts each channel once, from cfg_chan down to 0 and one conversion per channel, and then goes idle.
- R5: Mode 2 keeps converting channel cfg_chan. After cfg_en falls, at most one more conversion starts, and then busy falls and no further conversions start.
- R6: Mode 3 converts cfg_chan down to 0 and then starts again at cfg_chan. If cfg_en falls during a pass, that pass runs through channel 0 and the block then goes idle.
- R7: If cfg_multi = 0 in mode 1 or mode 3, each conversion after the first waits for a new trigger rising edge, and busy stays 1 while it waits. If cfg_multi = 1, the conversions follow each other with no further trigger.
- R8: cfg_trig_sel selects the trigger. Code 0 is the cfg_start strobe, and codes 1, 2 and 3 select ext_trig[0], ext_trig[1] and ext_trig[2]. Inputs that are not selected have no effect. With cfg_trig_inv = 1 the selected input is inverted before edge detection, so a falling input edge triggers.
- R9: When idle with cfg_en = 0, trigger edges are ignored. cfg_start may be raised in the same clock as cfg_en.
- R10: result loads only when conv_done arrives for a pending conversion. With cfg_twos = 0 it holds conv_data unchanged; with cfg_twos = 1 it holds conv_data with bit 9 inverted.
- R11: irq_flag is set by each result load and cleared by an irq_ack or irq_clr pulse. A load wins over a clear that arrives in the same clock.
- R12: busy is 1 from the clock after a trigger is accepted until the last conversion of the operation has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enable |
| cfg_start | input | 1 | Software start strobe |
| cfg_mode | input | 2 | Sequence mode, 0 to 3 |
| cfg_chan | input | 4 | Channel, or highest channel of a sequence |
| cfg_sht | input | 2 | Sample-time code |
| cfg_trig_sel | input | 2 | Trigger source select |
| cfg_trig_inv | input | 1 | Invert the selected trigger |
| cfg_div | input | 3 | Clock divide minus one |
| cfg_twos | input | 1 | Two's-complement output format |
| cfg_multi | input | 1 | Multiple-sample option |
| ext_trig | input | 3 | External timer trigger inputs |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result code |
| conv_start | output | 1 | One-clock converter start pulse |
| conv_chan | output | 4 | Channel being converted |
| result | output | 10 | Result register |
| busy | output | 1 | Operation active |
| irq_flag | output | 1 | Interrupt flag |

## Verification
The hardest cases to reach from the ports are the ones where cfg_en falls partway through a repeat operation, because the outcome depends on the exact phase at which it falls. The bench watches the start pulses of its converter model. It drops enable at a known point in mode 3, right after the second pass has started, and it drops enable after a few rounds in mode 2. It then checks the exact channel order that remains, or the limit of one extra conversion. A second hard case is an acknowledge that arrives in the same clock as a result load; the converter model raises irq_ack together with its own done strobe to create it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_SAMPLE,
    S_CONV
  } seq_state_t;

  localparam int MAX_SAMPLE = 64;
  localparam int SH_W       = $clog2(MAX_SAMPLE);

  // mode bit 0: walks channels; mode bit 1: repeats
  localparam int MODE_SEQ_BIT = 0;
  localparam int MODE_REP_BIT = 1;

  function automatic int unsigned sample_clocks(input logic [1:0] code);
    case (code)
      2'd0:    return 4;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return MAX_SAMPLE;
    endcase
  endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NUM_TRIG = 3,
  parameter int TSEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_req,
  input  logic [NUM_TRIG-1:0] ext_trig,
  input  logic [TSEL_W-1:0]   sel,
  input  logic                inv,
  output logic                trig_edge
);

  logic                sw_q;
  logic                lvl;
  logic                lvl_q;
  logic [NUM_TRIG:0]   src;

  // software strobe is captured for one clock, then falls again by itself
  always_ff @(posedge clk) begin
    if (rst) sw_q <= 1'b0;
    else     sw_q <= sw_req;
  end

  assign src = {ext_trig, sw_q};

  always_comb begin
    if (int'(sel) <= NUM_TRIG) lvl = src[sel] ^ inv;
    else                       lvl = inv;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign trig_edge = lvl & ~lvl_q;

endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == div);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [CHAN_W-1:0] chan_top,
  input  logic [1:0]        sht,
  input  logic              multi,
  input  logic              trig_edge,
  input  logic              div_tick,
  input  logic              conv_done,
  output logic              div_clr,
  output logic              load,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              busy
);

  seq_state_t        st, st_n;
  logic [CHAN_W-1:0] ch_n;
  logic [SH_W-1:0]   sh, sh_n, sh_load;
  logic              start_n;
  logic              more;

  assign sh_load = SH_W'(sample_clocks(sht) - 1);

  always_comb begin
    st_n    = st;
    ch_n    = conv_chan;
    sh_n    = sh;
    start_n = 1'b0;
    div_clr = 1'b0;
    load    = 1'b0;
    more    = 1'b0;
    case (st)
      S_IDLE: begin
        if (en && trig_edge) begin
          st_n    = S_SAMPLE;
          ch_n    = chan_top;
          sh_n    = sh_load;
          div_clr = 1'b1;
        end
      end
      S_WAIT: begin
        if (trig_edge) begin
          st_n    = S_SAMPLE;
          sh_n    = sh_load;
          div_clr = 1'b1;
        end
      end
      S_SAMPLE: begin
        if (div_tick) begin
          if (sh == '0) begin
            st_n    = S_CONV;
            start_n = 1'b1;
          end else begin
            sh_n = sh - 1'b1;
          end
        end
      end
      default: begin
        if (conv_done) begin
          load = 1'b1;
          case ({mode[MODE_REP_BIT], mode[MODE_SEQ_BIT]})
            2'b00:   more = 1'b0;
            2'b01:   more = (conv_chan != '0);
            2'b10:   more = en;
            default: more = (conv_chan != '0) || en;
          endcase
          if (more) begin
            if (mode[MODE_SEQ_BIT])
              ch_n = (conv_chan == '0) ? chan_top : conv_chan - 1'b1;
            if (multi) begin
              st_n    = S_SAMPLE;
              sh_n    = sh_load;
              div_clr = 1'b1;
            end else begin
              st_n = S_WAIT;
            end
          end else begin
            st_n = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      sh         <= '0;
      conv_chan  <= '0;
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      st         <= st_n;
      sh         <= sh_n;
      conv_chan  <= ch_n;
      conv_start <= start_n;
      busy       <= (st_n != S_IDLE);
    end
  end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              twos,
  input  logic              ack,
  input  logic              clr,
  output logic [DATA_W-1:0] result,
  output logic              irq
);

  logic [DATA_W-1:0] fmt;

  // offset binary to two's complement: flip the sign position
  assign fmt = twos ? {~data[DATA_W-1], data[DATA_W-2:0]} : data;

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (load) result <= fmt;
  end

  always_ff @(posedge clk) begin
    if (rst)              irq <= 1'b0;
    else if (load)        irq <= 1'b1;
    else if (ack || clr)  irq <= 1'b0;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DATA_W   = 10,
  parameter int CHAN_W   = 4,
  parameter int NUM_TRIG = 3,
  parameter int DIV_W    = 3,
  parameter int TSEL_W   = $clog2(NUM_TRIG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic                cfg_start,
  input  logic [1:0]          cfg_mode,
  input  logic [CHAN_W-1:0]   cfg_chan,
  input  logic [1:0]          cfg_sht,
  input  logic [TSEL_W-1:0]   cfg_trig_sel,
  input  logic                cfg_trig_inv,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_twos,
  input  logic                cfg_multi,
  input  logic [NUM_TRIG-1:0] ext_trig,
  input  logic                irq_ack,
  input  logic                irq_clr,
  input  logic                conv_done,
  input  logic [DATA_W-1:0]   conv_data,
  output logic                conv_start,
  output logic [CHAN_W-1:0]   conv_chan,
  output logic [DATA_W-1:0]   result,
  output logic                busy,
  output logic                irq_flag
);

  logic trig_edge;
  logic div_clr;
  logic div_tick;
  logic res_load;

  adc_trig_sel #(.NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W)) u_trig (
    .clk(clk), .rst(rst), .sw_req(cfg_start), .ext_trig(ext_trig),
    .sel(cfg_trig_sel), .inv(cfg_trig_inv), .trig_edge(trig_edge)
  );

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(div_clr), .div(cfg_div), .tick(div_tick)
  );

  adc_seq_fsm #(.CHAN_W(CHAN_W)) u_fsm (
    .clk(clk), .rst(rst), .en(cfg_en), .mode(cfg_mode), .chan_top(cfg_chan),
    .sht(cfg_sht), .multi(cfg_multi), .trig_edge(trig_edge),
    .div_tick(div_tick), .conv_done(conv_done), .div_clr(div_clr),
    .load(res_load), .conv_start(conv_start), .conv_chan(conv_chan),
    .busy(busy)
  );

  adc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .load(res_load), .data(conv_data),
    .twos(cfg_twos), .ack(irq_ack), .clr(irq_clr), .result(result),
    .irq(irq_flag)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              conv_start,
  input logic              busy,
  input logic              irq_flag,
  input logic              irq_ack,
  input logic              irq_clr,
  input logic              load,
  input logic [DATA_W-1:0] result
);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg_en) |=> !busy);

  p_result_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(result));

  p_irq_set_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> irq_flag);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_ack && !irq_clr) |=> irq_flag);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!irq_flag && !load) |=> !irq_flag);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .conv_start(conv_start),
  .busy(busy), .irq_flag(irq_flag), .irq_ack(irq_ack), .irq_clr(irq_clr),
  .load(res_load), .result(result)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0, cfg_start = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [3:0] cfg_chan = 4'd0;
  logic [1:0] cfg_sht = 2'd0;
  logic [1:0] cfg_trig_sel = 2'd0;
  logic       cfg_trig_inv = 1'b0;
  logic [2:0] cfg_div = 3'd0;
  logic       cfg_twos = 1'b0, cfg_multi = 1'b0;
  logic [2:0] ext_trig = 3'd0;
  logic       irq_ack = 1'b0, irq_clr = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = 10'd0;
  logic       conv_start;
  logic [3:0] conv_chan;
  logic [9:0] result;
  logic       busy, irq_flag;

  always #2.5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_start(cfg_start),
    .cfg_mode(cfg_mode), .cfg_chan(cfg_chan), .cfg_sht(cfg_sht),
    .cfg_trig_sel(cfg_trig_sel), .cfg_trig_inv(cfg_trig_inv),
    .cfg_div(cfg_div), .cfg_twos(cfg_twos), .cfg_multi(cfg_multi),
    .ext_trig(ext_trig), .irq_ack(irq_ack), .irq_clr(irq_clr),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_chan(conv_chan), .result(result), .busy(busy), .irq_flag(irq_flag)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // converter model: done three clocks after each start pulse
  int       nconv = 0;
  int       chans [0:255];
  int       lat = 0;
  bit       pend = 1'b0;
  bit       collide = 1'b0;
  bit       ack_drop = 1'b0;
  logic [9:0] exp_res = '0;

  always @(negedge clk) begin
    if (ack_drop) begin
      irq_ack  = 1'b0;
      ack_drop = 1'b0;
    end
    if (pend) begin
      check(result == exp_res, "R10 result", int'(result), int'(exp_res));
      check(irq_flag == 1'b1, "R11 irq set on load", int'(irq_flag), 1);
      pend = 1'b0;
    end
    if (conv_done) begin
      conv_done = 1'b0;
      pend = 1'b1;
    end
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        conv_data = 10'((nconv * 37 + 11 * chans[(nconv - 1) % 256] + 300) % 1024);
        exp_res   = cfg_twos ? {~conv_data[9], conv_data[8:0]} : conv_data;
        conv_done = 1'b1;
        if (collide) begin
          irq_ack  = 1'b1;
          ack_drop = 1'b1;
        end
      end
    end
    if (conv_start) begin
      chans[nconv % 256] = int'(conv_chan);
      nconv++;
      lat = 2;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    cyc(4);
  endtask

  task automatic sw_pulse();
    @(negedge clk);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic ext_pulse(input int idx);
    @(negedge clk);
    ext_trig[idx] = 1'b1;
    @(negedge clk);
    ext_trig[idx] = 1'b0;
  endtask

  int seen_at;

  task automatic wait_count(input int target);
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (nconv >= target) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) chans[i] = 0;
    cyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(irq_flag == 1'b0, "R1 irq_flag", int'(irq_flag), 0);
    check(conv_start == 1'b0, "R1 conv_start", int'(conv_start), 0);
    check(result == 10'd0, "R1 result", int'(result), 0);

    // R2 / R3 / R12 sweep of sample code and divider in mode 0
    cfg_en = 1'b1; cfg_mode = 2'd0; cfg_chan = 4'd7;
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 8; d++) begin
        int n_samp;
        int cnt;
        int base;
        n_samp = (s == 3) ? 64 : (4 << s);
        @(negedge clk);
        cfg_sht = 2'(s); cfg_div = 3'(d); cfg_twos = d[0];
        base = nconv;
        cfg_start = 1'b1;
        cnt = 0;
        for (int k = 0; k < 1000; k++) begin
          @(posedge clk);
          cnt++;
          @(negedge clk);
          cfg_start = 1'b0;
          if (cnt == 2) check(busy == 1'b1, "R12 busy after accept", int'(busy), 1);
          if (conv_start) break;
        end
        check(cnt == 2 + n_samp * (d + 1), "R2 sample timing", cnt, 2 + n_samp * (d + 1));
        wait_idle();
        check(nconv == base + 1, "R3 single conversion count", nconv - base, 1);
        check(chans[base % 256] == 7, "R3 channel", chans[base % 256], 7);
        check(busy == 1'b0, "R3 idle after one", int'(busy), 0);
      end
    end

    // R4 / R7 sequence once, back to back
    cfg_sht = 2'd0; cfg_div = 3'd0; cfg_twos = 1'b0;
    cfg_mode = 2'd1; cfg_chan = 4'd5; cfg_multi = 1'b1;
    seen_at = nconv;
    sw_pulse();
    wait_idle();
    check(nconv - seen_at == 6, "R4 sequence length", nconv - seen_at, 6);
    for (int i = 0; i < 6; i++)
      check(chans[(seen_at + i) % 256] == 5 - i, "R4 channel order", chans[(seen_at + i) % 256], 5 - i);
    cfg_chan = 4'd0;
    seen_at = nconv;
    sw_pulse();
    wait_idle();
    check(nconv - seen_at == 1, "R4 sequence from channel 0", nconv - seen_at, 1);

    // R7 one trigger per conversion, external trigger 0
    cfg_chan = 4'd3; cfg_multi = 1'b0; cfg_trig_sel = 2'd1;
    seen_at = nconv;
    for (int p = 1; p <= 4; p++) begin
      ext_pulse(0);
      cyc(40);
      check(nconv - seen_at == p, "R7 one conversion per edge", nconv - seen_at, p);
      check(busy == (p < 4), "R7 busy while waiting", int'(busy), int'(p < 4));
      check(chans[(nconv - 1) % 256] == 4 - p, "R7 channel", chans[(nconv - 1) % 256], 4 - p);
    end

    // R8 trigger selection
    cfg_mode = 2'd0; cfg_chan = 4'd2; cfg_trig_sel = 2'd2;
    cyc(2);
    seen_at = nconv;
    ext_pulse(0);
    ext_pulse(2);
    sw_pulse();
    cyc(40);
    check(nconv == seen_at, "R8 unselected inputs ignored", nconv - seen_at, 0);
    check(busy == 1'b0, "R8 stays idle", int'(busy), 0);
    ext_pulse(1);
    cyc(40);
    check(nconv == seen_at + 1, "R8 selected input triggers", nconv - seen_at, 1);
    cfg_en = 1'b0; cfg_trig_sel = 2'd3; cfg_trig_inv = 1'b1;
    cyc(3);
    cfg_en = 1'b1;
    cyc(5);
    seen_at = nconv;
    ext_trig[2] = 1'b1;
    cyc(30);
    check(nconv == seen_at, "R8 inverted rising ignored", nconv - seen_at, 0);
    ext_trig[2] = 1'b0;
    cyc(40);
    check(nconv == seen_at + 1, "R8 inverted falling triggers", nconv - seen_at, 1);

    // R9 enable low ignores triggers; start with enable in one clock
    cfg_en = 1'b0; cfg_trig_inv = 1'b0; cfg_trig_sel = 2'd0;
    cyc(3);
    seen_at = nconv;
    sw_pulse();
    cyc(40);
    check(nconv == seen_at, "R9 ignored while disabled", nconv - seen_at, 0);
    check(busy == 1'b0, "R9 idle while disabled", int'(busy), 0);
    @(negedge clk);
    cfg_en = 1'b1; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    cyc(40);
    check(nconv == seen_at + 1, "R9 start with enable", nconv - seen_at, 1);

    // R11 acknowledge and software clear
    check(irq_flag == 1'b1, "R11 flag pending", int'(irq_flag), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(irq_flag == 1'b0, "R11 cleared by ack", int'(irq_flag), 0);
    sw_pulse();
    cyc(40);
    check(irq_flag == 1'b1, "R11 set again", int'(irq_flag), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq_flag == 1'b0, "R11 cleared by clr", int'(irq_flag), 0);
    collide = 1'b1;
    sw_pulse();
    cyc(40);
    collide = 1'b0;
    check(irq_flag == 1'b1, "R11 load wins over ack", int'(irq_flag), 1);

    // R5 repeat single channel
    cfg_mode = 2'd2; cfg_chan = 4'd9; cfg_multi = 1'b1; cfg_twos = 1'b1;
    seen_at = nconv;
    sw_pulse();
    wait_count(seen_at + 3);
    @(negedge clk);
    begin
      int at_drop;
      at_drop = nconv;
      cfg_en = 1'b0;
      wait_idle();
      check(nconv - at_drop <= 1, "R5 at most one after disable", nconv - at_drop, 1);
      at_drop = nconv;
      cyc(60);
      check(nconv == at_drop, "R5 stopped", nconv - at_drop, 0);
      check(busy == 1'b0, "R5 idle", int'(busy), 0);
    end
    for (int i = seen_at; i < nconv; i++)
      check(chans[i % 256] == 9, "R5 channel", chans[i % 256], 9);

    // R6 repeat sequence, disable mid pass
    @(negedge clk);
    cfg_en = 1'b1; cfg_mode = 2'd3; cfg_chan = 4'd2; cfg_twos = 1'b0;
    seen_at = nconv;
    sw_pulse();
    wait_count(seen_at + 4);
    @(negedge clk);
    cfg_en = 1'b0;
    wait_idle();
    cyc(40);
    check(nconv - seen_at == 6, "R6 pass completes", nconv - seen_at, 6);
    for (int i = 0; i < 6; i++)
      check(chans[(seen_at + i) % 256] == 2 - (i % 3), "R6 channel order",
            chans[(seen_at + i) % 256], 2 - (i % 3));
    check(busy == 1'b0, "R6 idle", int'(busy), 0);

    finish_run();
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule